// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Generator

This block turns status events from a FIFO-buffered serial port into interrupt and DMA request lines. The transmit FIFO, the receive FIFO and the receiver each send one-cycle event pulses. The block catches each pulse in a sticky status flag. Each flag then drives four separate interrupt lines and two DMA request lines. The interrupt lines are for transmit space, receive data, receive error and break. The DMA request lines are for transmit and receive. The interrupt lines are gated by enable bits from the control register. The DMA request lines ignore those enables, so a DMA controller can move data while the interrupts stay masked.

Software reads the status word and clears a flag by writing 0 to its bit. The clear only takes effect if the flag was read as 1 after it was set. A DMA acknowledge clears the flags its transfer serves. This also drops the matching interrupt without any software handler. A mode input selects asynchronous or clocked-synchronous operation. The data-ready event feeds the receive request only in asynchronous mode.

Top module: `serq_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no events, every request output and every status bit is 0.
- R2: An event pulse sets its flag, which shows on `stat_o` on the following clock and stays set until it is cleared. Bit order: 0 tx space, 1 rx full, 2 rx data ready, 3 break, 4 overrun, 5 rx error.
- R3: `irq_tx` is 1 exactly one clock after a cycle in which `en_tx` is 1 and the tx space flag is 1.
- R4: `dreq_tx` is 1 one clock after the tx space flag is 1, whatever the value of `en_tx`.
- R5: `irq_rx` is 1 one clock after a cycle in which `en_rx` is 1 and the rx source is active. The rx source is active when rx full is set, or when rx data ready is set and `async_mode` is 1.
- R6: `dreq_rx` follows the rx source one clock later, whatever `en_rx` is. With `async_mode`=0, the rx data ready flag drives neither `dreq_rx` nor `irq_rx`.
- R7: Error and break interrupts are enabled when `en_rx` or `en_err` is 1. `irq_err` follows the rx error flag. `irq_brk` follows break OR overrun. Both follow one clock later and are masked when both enables are 0.
- R8: Writing 0 to a flag bit clears it only if that flag was read as 1 (`rd_en` while set) since it was last set. Writing 1, or writing 0 without a prior read, leaves the flag unchanged.
- R9: When a set event and a clear arrive in the same cycle, the flag stays set.
- R10: `dma_tx_ack` clears the tx space flag. `dma_rx_ack` clears the rx full and rx data ready flags. The matching requests drop one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_space | input | 1 | Transmit FIFO empty event pulse |
| ev_rx_full | input | 1 | Receive FIFO full event pulse |
| ev_rx_ready | input | 1 | Receive data ready event pulse |
| ev_break | input | 1 | Break detected event pulse |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_rx_err | input | 1 | Receive error event pulse |
| en_tx | input | 1 | Transmit interrupt enable |
| en_rx | input | 1 | Receive interrupt enable |
| en_err | input | 1 | Error/break interrupt enable |
| async_mode | input | 1 | 1 = asynchronous, 0 = clocked synchronous |
| rd_en | input | 1 | Status read strobe |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 6 | Status write data (0 clears armed flag) |
| dma_tx_ack | input | 1 | Transmit DMA transfer acknowledge |
| dma_rx_ack | input | 1 | Receive DMA transfer acknowledge |
| stat_o | output | 6 | Status flags |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Receive error interrupt |
| irq_brk | output | 1 | Break/overrun interrupt |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |

## Verification
The assertions check three rules on every cycle. Each request line must match its flag and enable terms from the previous cycle. A set event always leaves its flag set. A write of 1 never clears a flag. Other behaviours span several cycles, and only the bench scenarios can show them. These are the read-then-write-0 clear sequence, the lack of effect of a write without a prior read, and DMA acknowledges removing interrupts that are enabled. The same holds for the data-ready flag being ignored in synchronous mode. The bench runs random traffic against a bench reference model and adds directed sequences for each of these cases.

// File: rtl/serq_pkg.sv
package serq_pkg;
  localparam int unsigned NFLAG   = 6;
  localparam int unsigned F_TXSP  = 0;
  localparam int unsigned F_RXFL  = 1;
  localparam int unsigned F_RXDR  = 2;
  localparam int unsigned F_BRK   = 3;
  localparam int unsigned F_OVR   = 4;
  localparam int unsigned F_RXER  = 5;
endpackage

// File: rtl/serq_rst_sync.sv
module serq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/serq_flag.sv
module serq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic dma_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr;

  always_comb begin
    clr    = (wr_i & ~wbit_i & arm_q) | dma_clr_i;
    flag_d = set_i | (flag_q & ~clr);
    arm_d  = flag_d & ((arm_q & ~clr) | (rd_i & flag_q)) & ~set_i;
    if (set_i & flag_q) arm_d = flag_d & ((arm_q & ~clr) | rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R9: a set event always leaves the flag set
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R8: a write of 1 with no DMA clear keeps a set flag
  p_write1_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i & wbit_i & ~dma_clr_i & flag_q) |=> flag_q);
  // R8: an unarmed flag survives a write of 0
  p_unarmed_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~arm_q & ~dma_clr_i) |=> flag_q);
endmodule

// File: rtl/serq_req.sv
module serq_req
  import serq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flag_i,
  input  logic             en_tx,
  input  logic             en_rx,
  input  logic             en_err,
  input  logic             async_mode,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err,
  output logic             irq_brk,
  output logic             dreq_tx,
  output logic             dreq_rx
);
  logic rx_src, err_gate;
  logic irq_tx_d, irq_rx_d, irq_err_d, irq_brk_d, dreq_tx_d, dreq_rx_d;

  always_comb begin
    rx_src    = flag_i[F_RXFL] | (async_mode & flag_i[F_RXDR]);
    err_gate  = en_rx | en_err;
    irq_tx_d  = en_tx & flag_i[F_TXSP];
    dreq_tx_d = flag_i[F_TXSP];
    irq_rx_d  = en_rx & rx_src;
    dreq_rx_d = rx_src;
    irq_err_d = err_gate & flag_i[F_RXER];
    irq_brk_d = err_gate & (flag_i[F_BRK] | flag_i[F_OVR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
      irq_brk <= 1'b0;
      dreq_tx <= 1'b0;
      dreq_rx <= 1'b0;
    end else begin
      irq_tx  <= irq_tx_d;
      irq_rx  <= irq_rx_d;
      irq_err <= irq_err_d;
      irq_brk <= irq_brk_d;
      dreq_tx <= dreq_tx_d;
      dreq_rx <= dreq_rx_d;
    end
  end

  p_irq_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tx & flag_i[F_TXSP]) |=> irq_tx);
  p_dreq_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_i[F_TXSP] |=> dreq_tx);
  p_irq_rx_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rx |=> !irq_rx);
  p_sync_dr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode & !flag_i[F_RXFL]) |=> !dreq_rx);
  p_err_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rx & !en_err) |=> (!irq_err & !irq_brk));
  p_brk_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_err & flag_i[F_OVR]) |=> irq_brk);
endmodule

// File: rtl/serq_gen.sv
module serq_gen
  import serq_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tx_space,
  input  logic             ev_rx_full,
  input  logic             ev_rx_ready,
  input  logic             ev_break,
  input  logic             ev_overrun,
  input  logic             ev_rx_err,
  input  logic             en_tx,
  input  logic             en_rx,
  input  logic             en_err,
  input  logic             async_mode,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [NFLAG-1:0] wr_data,
  input  logic             dma_tx_ack,
  input  logic             dma_rx_ack,
  output logic [NFLAG-1:0] stat_o,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err,
  output logic             irq_brk,
  output logic             dreq_tx,
  output logic             dreq_rx
);
  logic             rst_n_s;
  logic [NFLAG-1:0] ev_vec;
  logic [NFLAG-1:0] dma_clr;
  logic [NFLAG-1:0] flags;

  serq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[F_TXSP]  = ev_tx_space;
    ev_vec[F_RXFL]  = ev_rx_full;
    ev_vec[F_RXDR]  = ev_rx_ready;
    ev_vec[F_BRK]   = ev_break;
    ev_vec[F_OVR]   = ev_overrun;
    ev_vec[F_RXER]  = ev_rx_err;
    dma_clr         = '0;
    dma_clr[F_TXSP] = dma_tx_ack;
    dma_clr[F_RXFL] = dma_rx_ack;
    dma_clr[F_RXDR] = dma_rx_ack;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    serq_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .set_i    (ev_vec[g]),
      .rd_i     (rd_en),
      .wr_i     (wr_en),
      .wbit_i   (wr_data[g]),
      .dma_clr_i(dma_clr[g]),
      .flag_o   (flags[g])
    );
  end

  serq_req u_req (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .flag_i    (flags),
    .en_tx     (en_tx),
    .en_rx     (en_rx),
    .en_err    (en_err),
    .async_mode(async_mode),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err),
    .irq_brk   (irq_brk),
    .dreq_tx   (dreq_tx),
    .dreq_rx   (dreq_rx)
  );

  assign stat_o = flags;

  // R10: a DMA ack without a new event removes the tx flag
  p_dma_tx_clr_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dma_tx_ack & ~ev_tx_space) |=> !stat_o[F_TXSP]);
endmodule

// File: tb/serq_gen_tb_top.sv
module serq_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_space = 0, ev_rx_full = 0, ev_rx_ready = 0, ev_break = 0, ev_overrun = 0, ev_rx_err = 0;
  logic en_tx = 0, en_rx = 0, en_err = 0, async_mode = 1;
  logic rd_en = 0, wr_en = 0, dma_tx_ack = 0, dma_rx_ack = 0;
  logic [5:0] wr_data = '1;
  logic [5:0] stat_o;
  logic irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serq_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_space(ev_tx_space), .ev_rx_full(ev_rx_full), .ev_rx_ready(ev_rx_ready),
    .ev_break(ev_break), .ev_overrun(ev_overrun), .ev_rx_err(ev_rx_err),
    .en_tx(en_tx), .en_rx(en_rx), .en_err(en_err), .async_mode(async_mode),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack),
    .stat_o(stat_o), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .irq_brk(irq_brk), .dreq_tx(dreq_tx), .dreq_rx(dreq_rx)
  );

  // reference model built from the requirements
  logic [5:0] m_flag, m_arm;
  logic m_itx, m_irx, m_ierr, m_ibrk, m_dtx, m_drx;

  function automatic logic [5:0] ev_word();
    return {ev_rx_err, ev_overrun, ev_break, ev_rx_ready, ev_rx_full, ev_tx_space};
  endfunction

  function automatic logic [5:0] clr_word(input logic [5:0] arm);
    logic [5:0] c;
    c = (wr_en ? (~wr_data & arm) : 6'b0);
    c[0] = c[0] | dma_tx_ack;
    c[1] = c[1] | dma_rx_ack;
    c[2] = c[2] | dma_rx_ack;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag <= '0; m_arm <= '0;
      m_itx <= 0; m_irx <= 0; m_ierr <= 0; m_ibrk <= 0; m_dtx <= 0; m_drx <= 0;
    end else begin
      logic [5:0] ev, c, nf, na;
      logic src;
      ev = ev_word();
      c  = clr_word(m_arm);
      nf = ev | (m_flag & ~c);
      for (int i = 0; i < 6; i++) begin
        if (ev[i]) na[i] = m_flag[i] & ((m_arm[i] & ~c[i]) | rd_en);
        else       na[i] = nf[i] & ((m_arm[i] & ~c[i]) | (rd_en & m_flag[i]));
      end
      m_flag <= nf;
      m_arm  <= na;
      src    = m_flag[1] | (async_mode & m_flag[2]);
      m_itx  <= en_tx & m_flag[0];
      m_dtx  <= m_flag[0];
      m_irx  <= en_rx & src;
      m_drx  <= src;
      m_ierr <= (en_rx | en_err) & m_flag[5];
      m_ibrk <= (en_rx | en_err) & (m_flag[3] | m_flag[4]);
    end
  end

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2/R8/R9/R10 stat", stat_o, m_flag);
    chk("R3 irq_tx", {5'b0, irq_tx}, {5'b0, m_itx});
    chk("R4 dreq_tx", {5'b0, dreq_tx}, {5'b0, m_dtx});
    chk("R5 irq_rx", {5'b0, irq_rx}, {5'b0, m_irx});
    chk("R6 dreq_rx", {5'b0, dreq_rx}, {5'b0, m_drx});
    chk("R7 irq_err", {5'b0, irq_err}, {5'b0, m_ierr});
    chk("R7 irq_brk", {5'b0, irq_brk}, {5'b0, m_ibrk});
  endtask

  task automatic idle();
    {ev_tx_space, ev_rx_full, ev_rx_ready, ev_break, ev_overrun, ev_rx_err} = '0;
    rd_en = 0; wr_en = 0; wr_data = '1; dma_tx_ack = 0; dma_rx_ack = 0;
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5e71));
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", {stat_o}, 6'b0);
    chk("R1 reset", {irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx}, 6'b0);
    rst_n = 1;
    repeat (4) step();
    chk("R1 after release", {irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx}, 6'b0);

    // R6: sync mode, data ready alone gives no rx request
    async_mode = 0; en_rx = 1;
    ev_rx_ready = 1; step(); idle(); step(); step();
    chk("R6 sync dr ignored", {5'b0, dreq_rx | irq_rx}, 6'b0);
    async_mode = 1; step(); step();
    chk("R6 async dr counts", {4'b0, dreq_rx, irq_rx}, 6'b11);
    // R10: rx ack clears ready and drops requests
    dma_rx_ack = 1; step(); idle(); step();
    chk("R10 rx ack", {4'b0, dreq_rx, irq_rx}, 6'b0);

    // R8: write 0 without prior read keeps the flag
    ev_break = 1; step(); idle();
    wr_en = 1; wr_data = 6'b0; step(); idle(); step();
    chk("R8 unread write keeps", {5'b0, stat_o[3]}, 6'b1);
    // R8: write 1 after read keeps; then write 0 clears
    rd_en = 1; step(); idle();
    wr_en = 1; wr_data = 6'h3f; step(); idle(); step();
    chk("R8 write1 keeps", {5'b0, stat_o[3]}, 6'b1);
    wr_en = 1; wr_data = 6'h37; step(); idle(); step();
    chk("R8 read then write0 clears", {5'b0, stat_o[3]}, 6'b0);

    // R9: set and clear in the same cycle
    ev_rx_err = 1; step(); idle();
    rd_en = 1; step(); idle();
    ev_rx_err = 1; wr_en = 1; wr_data = 6'h1f; step(); idle(); step();
    chk("R9 set wins", {5'b0, stat_o[5]}, 6'b1);

    // R7: error enable alone passes error/break, not rx data
    en_rx = 0; en_err = 1; ev_rx_full = 1; ev_overrun = 1; step(); idle(); step(); step();
    chk("R7 err gate", {2'b0, irq_err, irq_brk, irq_rx, dreq_rx}, 6'b1101);
    en_err = 0; step(); step();
    chk("R7 masked", {4'b0, irq_err, irq_brk}, 6'b0);

    // R3/R4/R10: tx request without enable, then ack
    en_tx = 0; ev_tx_space = 1; step(); idle(); step();
    chk("R4 dreq without enable", {4'b0, dreq_tx, irq_tx}, 6'b10);
    en_tx = 1; step(); step();
    chk("R3 irq with enable", {5'b0, irq_tx}, 6'b1);
    dma_tx_ack = 1; step(); idle(); step();
    chk("R10 tx ack", {4'b0, dreq_tx, irq_tx}, 6'b0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      ev_tx_space = ($urandom % 8) == 0;
      ev_rx_full  = ($urandom % 8) == 0;
      ev_rx_ready = ($urandom % 8) == 0;
      ev_break    = ($urandom % 12) == 0;
      ev_overrun  = ($urandom % 12) == 0;
      ev_rx_err   = ($urandom % 12) == 0;
      rd_en       = ($urandom % 3) == 0;
      wr_en       = ($urandom % 4) == 0;
      wr_data     = 6'($urandom);
      dma_tx_ack  = ($urandom % 6) == 0;
      dma_rx_ack  = ($urandom % 6) == 0;
      if ((n % 50) == 0) begin
        en_tx = 1'($urandom); en_rx = 1'($urandom);
        en_err = 1'($urandom); async_mode = 1'($urandom);
      end
      step();
    end
    idle(); step();
    done = 1;
    finish_run();
  end
endmodule